// File: doc/BRIEF.md
# Inter-processor interrupt queue controller

This block lets the cores of a multi-core cluster post numbered interrupts to one another. Every core owns a first-in first-out queue of pending interrupt numbers and a single interrupt line that stays high while that queue holds anything. A core sends an interrupt with one register write. The write either targets one named core, or every core except the named one. That second form lets a core signal all of its peers without signalling itself.

The receiving core drains its queue through one shared pop address. A requester-ID sideband on the access selects whose queue is touched. A read pops and returns the oldest number. A read of an empty queue returns 0, so interrupt number 0 is reserved as "nothing pending". A write to the pop address throws away everything pending for the requester. When a queue is full, a new number for it is dropped and a sticky per-core overflow flag records the loss. Software can read that flag and clear it.

The register word is DATA_W bits wide. The interrupt number sits in bits [DATA_W-1:16] and the target core index in bits [15:0]. Registers are selected by `acc_addr`.

Top module: `ipi_queue_ctrl`

## Requirements
- R1: After reset every irq bit is 0, every queue is empty, and the status register reads 0.
- R2: A write to address 0 with data {num, target} appends num to the queue of core `target` only. That core's irq bit is 1 from the clock edge that takes the write.
- R3: A write to address 1 with data {num, target} appends num to the queue of every core except `target`. When `target` is not below N_CORES, every core receives it.
- R4: A read at any address gives `rd_valid`=1 and the result on `rd_data` in the cycle after the access. In every other cycle `rd_valid`=0 and `rd_data`=0.
- R5: A read at address 2 by requester c returns the oldest number in c's queue, zero-extended, and removes it. Numbers therefore come out in the order they were sent.
- R6: A read at address 2 by a requester whose queue is empty returns 0 and changes no state.
- R7: A write at address 2 by requester c empties c's queue and leaves all other queues untouched.
- R8: irq[c] stays 1 while c's queue holds an entry. It falls at the edge of the access at address 2 that leaves the queue empty.
- R9: A number sent to a core whose queue already holds DEPTH entries is dropped. Older entries are kept, and bit c of the status register (address 3) becomes 1 and stays 1.
- R10: A write to address 3 clears each status bit written as 1 and leaves status bits written as 0 unchanged.
- R11: A write to address 0 whose target is not below N_CORES changes no queue and no irq bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register index: 0 send-one, 1 send-all-but, 2 pop, 3 status |
| acc_wdata | input | DATA_W | Write data: number in [DATA_W-1:16], target in [15:0] |
| acc_src | input | ID_W | Index of the requesting core |
| rd_valid | output | 1 | Read result present |
| rd_data | output | DATA_W | Read result |
| irq | output | N_CORES | Per-core interrupt line, high while its queue is not empty |

## Verification
Two situations are hard to reach. The first is a full queue that takes one more send while its older entries must survive. The second is a queue that must keep its irq bit high through several pops before it falls on the last one. The stimulus fills one core's queue with five distinct numbers through repeated send-one writes. It then reads the sticky status bit and pops every entry, which confirms that exactly the first four come back in order and that the fifth left no trace. A send-all-but write whose target lies outside the core range checks the broadcast edge, in which no core is excluded.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   // Register indices. Software depends on these values.
   typedef enum logic [1:0] {
      REG_SEND_ONE     = 2'd0,
      REG_SEND_ALL_BUT = 2'd1,
      REG_POP          = 2'd2,
      REG_STATUS       = 2'd3
   } ipi_reg_e;

   // Low bits of a send word that carry the target core index.
   localparam int TGT_W = 16;

endpackage

// File: rtl/ipi_fifo.sv
// One core's queue of pending interrupt numbers.
module ipi_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         clear,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         dropped
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0] count;
   logic          do_pop, do_push, is_full;

   assign is_full = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty && !clear;
   // A pop in the same cycle frees the slot that the push needs.
   assign do_push = push && !clear && (!is_full || do_pop);
   assign dropped = push && !clear && !do_push;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push) wr_ptr <= wr_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

endmodule

// File: rtl/ipi_decode.sv
// Turns one register access into per-core push, pop and clear strobes.
module ipi_decode #(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 2
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [ID_W-1:0]   acc_src,
   output logic [N_CORES-1:0] push_mask,
   output logic [N_CORES-1:0] pop_mask,
   output logic [N_CORES-1:0] clr_mask,
   output logic              src_ok,
   output logic              is_pop_rd,
   output logic              is_stat_rd,
   output logic              is_stat_wr
);
   import ipi_pkg::*;

   localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(REG_SEND_ONE);
   localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(REG_SEND_ALL_BUT);
   localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(REG_POP);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);

   logic             wr, rd, send_one, send_all;
   logic [TGT_W-1:0] tgt;

   assign wr         = acc_valid && acc_write;
   assign rd         = acc_valid && !acc_write;
   assign send_one   = wr && (acc_addr == A_ONE);
   assign send_all   = wr && (acc_addr == A_ALL);
   assign is_pop_rd  = rd && (acc_addr == A_POP);
   assign is_stat_rd = rd && (acc_addr == A_STAT);
   assign is_stat_wr = wr && (acc_addr == A_STAT);
   assign tgt        = acc_wdata[TGT_W-1:0];
   assign src_ok     = (32'(acc_src) < 32'(N_CORES));

   generate
      for (genvar i = 0; i < N_CORES; i++) begin : g_core
         logic hit_tgt, hit_src;
         assign hit_tgt      = (tgt == TGT_W'(i));
         assign hit_src      = (acc_src == ID_W'(i));
         assign push_mask[i] = (send_one && hit_tgt) || (send_all && !hit_tgt);
         assign pop_mask[i]  = is_pop_rd && hit_src;
         assign clr_mask[i]  = wr && (acc_addr == A_POP) && hit_src;
      end
   endgenerate

endmodule

// File: rtl/ipi_queue_ctrl.sv
module ipi_queue_ctrl #(
   parameter int N_CORES = 4,
   parameter int DEPTH   = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DATA_W-1:0]  acc_wdata,
   input  logic [ID_W-1:0]    acc_src,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic [N_CORES-1:0] irq
);
   import ipi_pkg::*;

   localparam int NUM_W = DATA_W - TGT_W;

   generate
      if (DEPTH < 1)           begin : g_bad_depth $error("DEPTH must be at least 1"); end
      if (N_CORES < 2)         begin : g_bad_cores $error("N_CORES must be at least 2"); end
      if (N_CORES > DATA_W)    begin : g_bad_stat  $error("status needs N_CORES <= DATA_W"); end
      if (DATA_W <= TGT_W)     begin : g_bad_data  $error("DATA_W must exceed the target field"); end
      if (ADDR_W < 2)          begin : g_bad_addr  $error("ADDR_W must be at least 2"); end
      if ((1 << ID_W) < N_CORES) begin : g_bad_id  $error("ID_W too narrow for N_CORES"); end
   endgenerate

   logic [N_CORES-1:0] push_mask, pop_mask, clr_mask, empty, dropped, ovf_q;
   logic               src_ok, is_pop_rd, is_stat_rd, is_stat_wr;
   logic [NUM_W-1:0]   heads [N_CORES];
   logic [NUM_W-1:0]   num;

   assign num = acc_wdata[DATA_W-1:TGT_W];

   ipi_decode #(
      .N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
   ) u_dec (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_src   (acc_src),
      .push_mask (push_mask),
      .pop_mask  (pop_mask),
      .clr_mask  (clr_mask),
      .src_ok    (src_ok),
      .is_pop_rd (is_pop_rd),
      .is_stat_rd(is_stat_rd),
      .is_stat_wr(is_stat_wr)
   );

   generate
      for (genvar i = 0; i < N_CORES; i++) begin : g_q
         ipi_fifo #(.DEPTH(DEPTH), .W(NUM_W)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (push_mask[i]),
            .pop    (pop_mask[i]),
            .clear  (clr_mask[i]),
            .din    (num),
            .head   (heads[i]),
            .empty  (empty[i]),
            .dropped(dropped[i])
         );
         assign irq[i] = !empty[i];

         always_ff @(posedge clk) begin
            if (!rst_n)                                 ovf_q[i] <= 1'b0;
            else if (dropped[i])                        ovf_q[i] <= 1'b1;
            else if (is_stat_wr && acc_wdata[i])        ovf_q[i] <= 1'b0;
         end
      end
   endgenerate

   logic [NUM_W-1:0] sel_head;
   logic             sel_empty;

   always_comb begin
      sel_head  = '0;
      sel_empty = 1'b1;
      for (int i = 0; i < N_CORES; i++) begin
         if (acc_src == ID_W'(i)) begin
            sel_head  = heads[i];
            sel_empty = empty[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= acc_valid && !acc_write;
         if (is_pop_rd && src_ok && !sel_empty) rd_data <= {{TGT_W{1'b0}}, sel_head};
         else if (is_stat_rd)                   rd_data <= DATA_W'(ovf_q);
         else                                   rd_data <= '0;
      end
   end

endmodule

// File: rtl/ipi_queue_chk.sv
module ipi_queue_chk #(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic               acc_write,
   input logic [ADDR_W-1:0]  acc_addr,
   input logic [DATA_W-1:0]  acc_wdata,
   input logic [ID_W-1:0]    acc_src,
   input logic               rd_valid,
   input logic [DATA_W-1:0]  rd_data,
   input logic [N_CORES-1:0] irq,
   input logic [N_CORES-1:0] ovf
);
   import ipi_pkg::*;

   localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(REG_SEND_ONE);
   localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(REG_SEND_ALL_BUT);
   localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(REG_POP);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);

   logic is_send, is_rd, is_stat_wr;
   assign is_send    = acc_valid && acc_write && (acc_addr == A_ONE || acc_addr == A_ALL);
   assign is_rd      = acc_valid && !acc_write;
   assign is_stat_wr = acc_valid && acc_write && (acc_addr == A_STAT);

   a_r4_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rd_valid);
   a_r4_no_read_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rd_valid);
   a_r4_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   generate
      for (genvar i = 0; i < N_CORES; i++) begin : g_c
         a_r2_irq_rise_needs_send: assert property (@(posedge clk) disable iff (!rst_n)
            !irq[i] && !is_send |=> !irq[i]);
         a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
            is_rd && (acc_addr == A_POP) && (acc_src == ID_W'(i)) && !irq[i]
            |=> (rd_data == '0) && !irq[i]);
         a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && acc_write && (acc_addr == A_POP) && (acc_src == ID_W'(i))
            |=> !irq[i]);
         a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] && !(is_stat_wr && acc_wdata[i]) |=> ovf[i]);
         a_r8_irq_holds_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !(acc_valid && (acc_addr == A_POP) && (acc_src == ID_W'(i)))
            |=> irq[i]);
      end
   endgenerate

endmodule

bind ipi_queue_ctrl ipi_queue_chk #(
   .N_CORES(N_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_src(acc_src),
   .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .ovf(ovf_q)
);

// File: tb/sim_ipi_queue_ctrl.sv
`timescale 1ns/1ps
module sim_ipi_queue_ctrl;
   localparam int N = 4, D = 4, AW = 4, DW = 32, IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic [IW-1:0] acc_src = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [N-1:0]  irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ipi_queue_ctrl #(.N_CORES(N), .DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_src(acc_src),
      .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One access; results sampled just after the edge that takes it.
   task automatic bus(bit wr, int addr, logic [DW-1:0] data, int src,
                      output logic [DW-1:0] rdat);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_addr = AW'(addr);
      acc_wdata = data; acc_src = IW'(src);
      @(posedge clk); #1;
      rdat = rd_data;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   function automatic logic [DW-1:0] sw(int num, int tgt);
      return {16'(num), 16'(tgt)};
   endfunction

   task automatic t_reset();
      logic [DW-1:0] r;
      check("R1 irq after reset", DW'(irq), 0);
      bus(0, 3, 0, 0, r); check("R1 status after reset", r, 0);
      for (int c = 0; c < N; c++) begin
         bus(0, 2, 0, c, r); check("R6 pop of empty queue", r, 0);
      end
   endtask

   task automatic t_send_one();
      logic [DW-1:0] r;
      bus(1, 0, sw('h11, 2), 0, r);
      check("R2 send-one irq", DW'(irq), 'b0100);
      bus(0, 2, 0, 2, r); check("R5 pop value", r, 'h11);
      check("R8 irq falls on emptying pop", DW'(irq), 0);
   endtask

   task automatic t_send_all_but();
      logic [DW-1:0] r;
      bus(1, 1, sw('h22, 1), 3, r);
      check("R3 send-all-but irq", DW'(irq), 'b1101);
      bus(0, 2, 0, 1, r); check("R3 excluded core empty", r, 0);
      for (int c = 0; c < N; c++) begin
         if (c != 1) begin
            bus(0, 2, 0, c, r); check("R3 broadcast value", r, 'h22);
         end
      end
      check("R8 all irq low after drain", DW'(irq), 0);
   endtask

   task automatic t_order();
      logic [DW-1:0] r;
      for (int k = 0; k < 3; k++) bus(1, 0, sw('h31 + k, 3), 0, r);
      for (int k = 0; k < 3; k++) begin
         bus(0, 2, 0, 3, r); check("R5 FIFO order", r, DW'('h31 + k));
         check("R8 irq while entries remain", DW'(irq[3]), (k < 2) ? 1 : 0);
      end
   endtask

   task automatic t_clear();
      logic [DW-1:0] r;
      bus(1, 0, sw('h51, 0), 2, r);
      bus(1, 0, sw('h52, 0), 2, r);
      bus(1, 0, sw('h53, 1), 2, r);
      bus(1, 2, 'hFFFF, 0, r);
      check("R7 clear only own queue irq", DW'(irq), 'b0010);
      bus(0, 2, 0, 0, r); check("R7 cleared queue pops 0", r, 0);
      bus(0, 2, 0, 1, r); check("R7 other queue kept", r, 'h53);
   endtask

   task automatic t_overflow();
      logic [DW-1:0] r;
      for (int k = 0; k < D + 1; k++) bus(1, 0, sw('h41 + k, 2), 0, r);
      bus(0, 3, 0, 0, r); check("R9 overflow status bit", r, 'h4);
      for (int k = 0; k < D; k++) begin
         bus(0, 2, 0, 2, r); check("R9 older entries kept", r, DW'('h41 + k));
      end
      bus(0, 2, 0, 2, r); check("R9 dropped entry absent", r, 0);
      bus(0, 3, 0, 0, r); check("R9 status sticky after drain", r, 'h4);
   endtask

   task automatic t_w1c();
      logic [DW-1:0] r;
      bus(1, 3, 'hB, 0, r);
      bus(0, 3, 0, 0, r); check("R10 zero bits leave status", r, 'h4);
      bus(1, 3, 'h4, 0, r);
      bus(0, 3, 0, 0, r); check("R10 one bit clears status", r, 0);
   endtask

   task automatic t_out_of_range();
      logic [DW-1:0] r;
      bus(1, 0, sw('h61, 7), 0, r);
      check("R11 send-one out of range no irq", DW'(irq), 0);
      bus(0, 3, 0, 0, r); check("R11 no overflow either", r, 0);
      bus(1, 1, sw('h62, 9), 0, r);
      check("R3 all-but out of range hits all", DW'(irq), 'b1111);
      for (int c = 0; c < N; c++) begin
         bus(0, 2, 0, c, r); check("R3 all-but value", r, 'h62);
      end
      check("R8 irq low after drain", DW'(irq), 0);
   endtask

   task automatic t_rvalid();
      logic [DW-1:0] r;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 3;
      @(posedge clk); #1; check("R4 rd_valid after read", DW'(rd_valid), 1);
      @(negedge clk); acc_valid = 1'b0;
      @(posedge clk); #1; check("R4 rd_valid idle", DW'(rd_valid), 0);
      check("R4 rd_data idle", rd_data, 0);
      bus(1, 0, sw('h70, 0), 0, r); check("R4 write gives no data", r, 0);
      bus(1, 2, 0, 0, r);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_send_one();
      t_send_all_but();
      t_order();
      t_clear();
      t_overflow();
      t_w1c();
      t_out_of_range();
      t_rvalid();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule